// File: doc/BRIEF.md
# Paced FIFO-to-parallel stream reader

This block empties an external asynchronous byte FIFO and plays the bytes out on a registered 8-bit parallel output at a fixed rate. The FIFO signals that it holds data with an active-low flag. It hands over one byte for each active-low read strobe and releases its data bus between strobes. A slot generator divides the block clock by a programmable ratio. At each slot, the block issues one read strobe of programmable low time, but only when the synchronized flag reports data. If the flag reports no data, the slot is counted as an underrun instead.

Each byte is latched into the output register at the instant the strobe is released. The output keeps that byte through any gap in the stream, so the floating bus never reaches downstream logic. A saturating underrun counter shows how often the stream starved. A clear input resets the counter.

Top module: `paced_fifo_reader`

## Requirements
- R1: While reset is held, `rd_n` is 1, `out_data` is 0, `out_valid` is 0 and `underrun_cnt` is 0.
- R2: `avail_n` passes through two flip-flops before it is used. A low level driven three or more edges before a slot edge produces a strobe at that slot. A low level driven only two edges before the slot edge produces an underrun.
- R3: `rd_n` never goes low while the synchronized `avail_n` is 1.
- R4: Each strobe keeps `rd_n` low for exactly L clock cycles, where L = `low_len`, or L = 1 when `low_len` is 0.
- R5: The byte on `bus_in` is captured into `out_data` on the edge where `rd_n` returns to 1. `out_valid` is high for exactly that one cycle.
- R6: `out_data` changes only in a cycle where `out_valid` is high. Bus activity between strobes has no effect on it.
- R7: While data stays available, successive strobes start exactly N cycles apart, where N = `div_n` when `div_n` ≥ L+2.
- R8: When `div_n` < L+2, the slot spacing is clamped to L+2 cycles.
- R9: Each slot that finds no data adds one to `underrun_cnt`. The counter sticks at its all-ones maximum (255 by default).
- R10: `underrun_clr` sets `underrun_cnt` to 0 on the next edge. If a clear and an underrun slot fall on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | DIV_W | Slot spacing in clock cycles |
| low_len | input | LOW_W | Strobe low time in clock cycles (0 is treated as 1) |
| avail_n | input | 1 | Asynchronous active-low data-available flag from the FIFO |
| rd_n | output | 1 | Active-low read strobe to the FIFO |
| bus_in | input | DATA_W | FIFO data bus, valid only while the strobe is low |
| out_data | output | DATA_W | Held output byte |
| out_valid | output | 1 | One-cycle pulse when a new byte is captured |
| underrun_clr | input | 1 | Synchronous clear of the underrun counter |
| underrun_cnt | output | UND_W | Saturating count of slots that found no data |

## Verification
Two functions can fall on the same edge. One is a slot that finds the FIFO empty and bumps the underrun counter. The other is a software clear of that counter. The bench first locks onto the slot phase by watching the counter step. It then raises the clear for the single cycle that ends on the next slot edge and expects the counter to read 0, not 1. The bench uses the same phase lock to drop the data flag two and then three edges before a slot, which shows that the synchronizer delay decides between a strobe and an underrun.

// File: rtl/paced_fifo_reader.sv
module paced_fifo_reader #(
  parameter int DIV_W  = 8,
  parameter int LOW_W  = 4,
  parameter int UND_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_n,
  input  logic [LOW_W-1:0]  low_len,
  input  logic              avail_n,
  output logic              rd_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              underrun_clr,
  output logic [UND_W-1:0]  underrun_cnt
);
  localparam int CW = ((DIV_W > LOW_W) ? DIV_W : LOW_W) + 1;
  localparam logic [UND_W-1:0] UND_MAX = {UND_W{1'b1}};

  logic              avail_s1, avail_s2;
  logic [CW-1:0]     cnt;
  logic [LOW_W-1:0]  low_left;
  logic              rd_q;

  wire [LOW_W-1:0] low_eff = (low_len == '0) ? LOW_W'(1) : low_len;
  wire [CW-1:0]    min_div = CW'(low_eff) + CW'(2);
  wire [CW-1:0]    n_eff   = (CW'(div_n) < min_div) ? min_div : CW'(div_n);
  wire             slot    = (cnt == '0) && rd_q;
  wire             start   = slot && !avail_s2;
  wire             starve  = slot && avail_s2;

  assign rd_n = rd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {avail_s1, avail_s2} <= 2'b11;
    else        {avail_s1, avail_s2} <= {avail_n, avail_s1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     cnt <= '0;
    else if (cnt >= n_eff - CW'(1)) cnt <= '0;
    else                            cnt <= cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q      <= 1'b1;
      low_left  <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        rd_q     <= 1'b0;
        low_left <= low_eff;
      end else if (!rd_q) begin
        if (low_left <= LOW_W'(1)) begin
          rd_q      <= 1'b1;
          out_data  <= bus_in;
          out_valid <= 1'b1;
        end else begin
          low_left <= low_left - LOW_W'(1);
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               underrun_cnt <= '0;
    else if (underrun_clr)                    underrun_cnt <= '0;
    else if (starve && underrun_cnt != UND_MAX) underrun_cnt <= underrun_cnt + UND_W'(1);

  logic [LOW_W-1:0] chk_run, chk_want;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chk_run  <= '0;
      chk_want <= '0;
    end else if (start) begin
      chk_run  <= '0;
      chk_want <= low_eff;
    end else if (!rd_q) begin
      chk_run  <= chk_run + LOW_W'(1);
    end

  p_gate_by_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> !$past(avail_s2));
  p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> chk_run == chk_want);
  p_capture_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> out_valid);
  p_valid_only_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $rose(rd_n));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_cnt == UND_MAX && !underrun_clr) |=> underrun_cnt == UND_MAX);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_clr |=> underrun_cnt == '0);
endmodule

// File: tb/paced_fifo_reader_test.sv
module paced_fifo_reader_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, avail_n = 1'b1, underrun_clr = 1'b0;
  logic [7:0] div_n = 8'd10;
  logic [3:0] low_len = 4'd3;
  logic       rd_n, out_valid;
  logic [7:0] bus_in, out_data, underrun_cnt;

  int idx = 0;
  assign bus_in = rd_n ? 8'hEE : 8'(idx + 16);

  paced_fifo_reader uut (.clk(clk), .rst_n(rst_n), .div_n(div_n), .low_len(low_len),
    .avail_n(avail_n), .rd_n(rd_n), .bus_in(bus_in), .out_data(out_data),
    .out_valid(out_valid), .underrun_clr(underrun_clr), .underrun_cnt(underrun_cnt));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) cyc++;

  int falls = 0, rises = 0, last_fall = -1, last_period = 0, last_width = 0, hold_bad = 0;
  logic prev_rd = 1'b1;
  logic [7:0] prev_out = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rd && !rd_n) begin
        falls++;
        if (last_fall >= 0) last_period = cyc - last_fall;
        last_fall = cyc;
      end
      if (!prev_rd && rd_n) begin
        rises++;
        last_width = cyc - last_fall;
        chk(out_valid, "R5 valid at release", int'(out_valid), 1);
        chk(out_data == 8'(idx + 16), "R5 captured byte", int'(out_data), idx + 16);
        idx++;
      end else if (out_valid) hold_bad++;
      if (!out_valid && out_data != prev_out) hold_bad++;
    end
    prev_rd  = rd_n;
    prev_out = out_data;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_tick();
    logic [7:0] v = underrun_cnt;
    while (underrun_cnt == v) step(1);
  endtask

  task automatic t_reset();
    step(3);
    chk(rd_n == 1'b1, "R1 rd_n", int'(rd_n), 1);
    chk(out_data == 8'h00, "R1 out_data", int'(out_data), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(underrun_cnt == 8'h00, "R1 underrun_cnt", int'(underrun_cnt), 0);
    @(negedge clk) rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_stream(input int dv, input int lw, input int exp_n, input int exp_l, input string tag);
    avail_n = 1'b1;
    step(20);
    @(negedge clk);
    div_n = 8'(dv); low_len = 4'(lw);
    step(20);
    hold_bad = 0;
    last_fall = -1;
    @(negedge clk) avail_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      int f = falls;
      while (falls == f) step(1);
      if (k > 0) chk(last_period == exp_n, tag, last_period, exp_n);
    end
    begin
      int r = rises;
      while (rises == r) step(1);
      chk(last_width == exp_l, "R4 strobe low time", last_width, exp_l);
    end
    @(negedge clk) avail_n = 1'b1;
    step(30);
    chk(hold_bad == 0, "R6 output held between captures", hold_bad, 0);
  endtask

  task automatic t_starve();
    int f0, c0;
    avail_n = 1'b1;
    @(negedge clk);
    div_n = 8'd5; low_len = 4'd2;
    underrun_clr = 1'b1;
    @(negedge clk) underrun_clr = 1'b0;
    step(20);
    f0 = falls;
    wait_tick();
    c0 = cyc;
    wait_tick();
    chk(cyc - c0 == 5, "R9 one increment per slot", cyc - c0, 5);
    step(60);
    chk(falls == f0, "R3 no strobe without data", falls - f0, 0);
    chk(out_valid == 1'b0, "R3 no capture without data", int'(out_valid), 0);
  endtask

  task automatic t_saturate();
    @(negedge clk);
    div_n = 8'd3; low_len = 4'd1;
    step(900);
    chk(underrun_cnt == 8'hFF, "R9 saturation", int'(underrun_cnt), 255);
    step(12);
    chk(underrun_cnt == 8'hFF, "R9 stays saturated", int'(underrun_cnt), 255);
  endtask

  task automatic t_clear_race();
    @(negedge clk) underrun_clr = 1'b1;
    @(negedge clk) underrun_clr = 1'b0;
    #1;
    chk(underrun_cnt == 8'h00, "R10 clear", int'(underrun_cnt), 0);
    @(negedge clk);
    div_n = 8'd8; low_len = 4'd2;
    step(20);
    wait_tick();
    repeat (7) @(negedge clk);
    underrun_clr = 1'b1;
    @(negedge clk) underrun_clr = 1'b0;
    #1;
    chk(underrun_cnt == 8'h00, "R10 clear wins over slot", int'(underrun_cnt), 0);
    wait_tick();
    chk(underrun_cnt == 8'h01, "R10 counting resumes", int'(underrun_cnt), 1);
  endtask

  task automatic t_sync();
    int f, u;
    @(negedge clk);
    div_n = 8'd8; low_len = 4'd2;
    avail_n = 1'b1;
    step(20);
    wait_tick();
    repeat (5) @(negedge clk);
    avail_n = 1'b0;
    f = falls; u = int'(underrun_cnt);
    step(4);
    chk(falls == f + 1, "R2 flag three edges early gives strobe", falls - f, 1);
    chk(int'(underrun_cnt) == u, "R2 no underrun when early", int'(underrun_cnt), u);
    @(negedge clk) avail_n = 1'b1;
    step(20);
    wait_tick();
    repeat (6) @(negedge clk);
    avail_n = 1'b0;
    f = falls; u = int'(underrun_cnt);
    step(4);
    chk(falls == f, "R2 flag two edges early is too late", falls - f, 0);
    chk(int'(underrun_cnt) == u + 1, "R2 underrun when late", int'(underrun_cnt), u + 1);
    @(negedge clk) avail_n = 1'b1;
    step(20);
  endtask

  bit done = 1'b0;
  initial begin
    t_reset();
    t_stream(10, 3, 10, 3, "R7 slot spacing N=10");
    t_stream(6, 4, 6, 4, "R7 slot spacing at minimum N=6");
    t_stream(4, 5, 7, 5, "R8 clamped spacing");
    t_stream(0, 0, 3, 1, "R8 clamp with zero low time");
    t_starve();
    t_saturate();
    t_clear_race();
    t_sync();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule